// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is a down-counter with a load value, a control word and a level interrupt. Software reaches it through four word-aligned registers on a simple synchronous bus. The surrounding system supplies two single-cycle tick strobes, one slow and one fast. A select bit in the control word picks which strobe drives the count.

The counter decreases by one on each selected tick while it is enabled. A tick that finds the count at zero is an underflow, and it sets the interrupt. In one-shot mode the counter then holds at zero. In periodic mode it takes the load value again on that same tick. The interrupt stays high until software writes any data to the clear register. A write to the load register also replaces the current count at once, whether or not the counter is running.

The counter is driven by a three-state machine:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | Not enabled. |
| `ST_COUNT` | Counting. |
| `ST_EXPIRED` | A one-shot run has ended. |

The transitions are:

| From | To | Condition |
|------|----|-----------|
| `ST_IDLE` | `ST_COUNT` | The enable bit is set. |
| `ST_IDLE` or `ST_COUNT` | `ST_EXPIRED` | A one-shot underflow. |
| `ST_COUNT` or `ST_EXPIRED` | `ST_IDLE` | The enable bit is cleared. |
| `ST_EXPIRED` | `ST_COUNT` | A load write while enabled. |

Ticks are counted in `ST_IDLE` and `ST_COUNT` whenever the enable bit is set.

Top module: `dn_timer`

## Requirements
- R1: After reset, the load register, the current count and the control word all read as zero, the interrupt is low and the counter is disabled.
- R2: Writing the load register (byte offset 0x0) stores the data there. It also sets the current count (read at offset 0x4) to the same value after the write edge, including while counting.
- R3: The control word at offset 0x8 keeps only three bits: bit 0 is enable, bit 1 is mode (1 for periodic, 0 for one-shot) and bit 4 is tick select. All other bits are written and read as zero.
- R4: With tick select 0, only `slow_tick` counts. With tick select 1, only `fast_tick` counts. A tick on the strobe that is not selected leaves the count unchanged.
- R5: While the enable bit is 0, neither tick strobe changes the count.
- R6: While enabled and not expired, each selected tick lowers a non-zero count by exactly one.
- R7: In one-shot mode, a selected tick at count zero raises the interrupt. The count stays at zero, and later ticks have no effect.
- R8: In periodic mode, a selected tick at count zero raises the interrupt and loads the load value into the count on the same edge.
- R9: Once raised, the interrupt stays high until a write of any data to offset 0xC. That write drives it low.
- R10: Writes to offset 0x4 are ignored, and offset 0xC reads as zero.
- R11: In a cycle with both a load write and a selected tick, the load value wins and no decrement or underflow happens. In a cycle with both an underflow and a clear write, the interrupt ends up set.
- R12: After a one-shot run expires, a load write restarts counting from the new value. Clearing enable returns the counter to idle with its count held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier (1 = write) |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| slow_tick | input | 1 | Slow count strobe, one cycle wide |
| fast_tick | input | 1 | Fast count strobe, one cycle wide |
| irq | output | 1 | Level interrupt, high until cleared |

## Verification
Every register write and every tick strobe takes effect on the one rising edge that samples it. Read data is a combinational view of the registers, so each result can be read from `bus_rdata` and `irq` at the falling edge right after that rising edge.

The bench drives each stimulus for exactly one cycle between two falling edges and reads back at the second falling edge. It therefore never samples while a register is changing. Expected counts come from an arithmetic model of down-count, reload and hold, stepped once per driven tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // Word index taken from bus_addr[3:2]
    localparam logic [1:0] IDX_LOAD  = 2'd0;
    localparam logic [1:0] IDX_VALUE = 2'd1;
    localparam logic [1:0] IDX_CTRL  = 2'd2;
    localparam logic [1:0] IDX_CLEAR = 2'd3;

    // Control word bit positions
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_MODE_BIT = 1;
    localparam int CTL_SEL_BIT  = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cur_cnt,
    output logic [DATA_W-1:0] load_q,
    output logic              ctl_en,
    output logic              ctl_periodic,
    output logic              ctl_fast,
    output logic              load_wr,
    output logic              clr_wr,
    output logic [DATA_W-1:0] bus_rdata
);
    logic       wr_hit;
    logic       ctl_wr;
    logic [1:0] idx;

    assign idx    = bus_addr[3:2];
    assign wr_hit = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);

    assign load_wr = wr_hit && (idx == IDX_LOAD);
    assign ctl_wr  = wr_hit && (idx == IDX_CTRL);
    assign clr_wr  = wr_hit && (idx == IDX_CLEAR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q       <= '0;
            ctl_en       <= 1'b0;
            ctl_periodic <= 1'b0;
            ctl_fast     <= 1'b0;
        end else begin
            if (load_wr) begin
                load_q <= bus_wdata;
            end
            if (ctl_wr) begin
                ctl_en       <= bus_wdata[CTL_EN_BIT];
                ctl_periodic <= bus_wdata[CTL_MODE_BIT];
                ctl_fast     <= bus_wdata[CTL_SEL_BIT];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            IDX_LOAD:  bus_rdata = load_q;
            IDX_VALUE: bus_rdata = cur_cnt;
            IDX_CTRL: begin
                bus_rdata[CTL_EN_BIT]   = ctl_en;
                bus_rdata[CTL_MODE_BIT] = ctl_periodic;
                bus_rdata[CTL_SEL_BIT]  = ctl_fast;
            end
            IDX_CLEAR: bus_rdata = '0;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              ctl_en,
    input  logic              ctl_periodic,
    input  logic              ctl_fast,
    input  logic              load_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] cur_cnt,
    output tmr_state_e        state,
    output logic              irq
);
    tmr_state_e next_state;
    logic       sel_tick;
    logic       step;
    logic       underflow;

    assign sel_tick = ctl_fast ? fast_tick : slow_tick;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next_state;
        end
    end

    // Next-state logic
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE: begin
                if (underflow && !ctl_periodic) begin
                    next_state = ST_EXPIRED;
                end else if (ctl_en) begin
                    next_state = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (!ctl_en) begin
                    next_state = ST_IDLE;
                end else if (underflow && !ctl_periodic) begin
                    next_state = ST_EXPIRED;
                end
            end
            ST_EXPIRED: begin
                if (!ctl_en) begin
                    next_state = ST_IDLE;
                end else if (load_wr) begin
                    next_state = ST_COUNT;
                end
            end
            default: next_state = ST_IDLE;
        endcase
    end

    // Output decode: a load write in the same cycle suppresses the tick
    always_comb begin
        step      = 1'b0;
        underflow = 1'b0;
        unique case (state)
            ST_IDLE, ST_COUNT: begin
                step      = ctl_en && sel_tick && !load_wr;
                underflow = step && (cur_cnt == '0);
            end
            ST_EXPIRED: begin
                step      = 1'b0;
                underflow = 1'b0;
            end
            default: begin
                step      = 1'b0;
                underflow = 1'b0;
            end
        endcase
    end

    // Count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_cnt <= '0;
        end else if (load_wr) begin
            cur_cnt <= bus_wdata;
        end else if (underflow) begin
            cur_cnt <= ctl_periodic ? load_q : '0;
        end else if (step) begin
            cur_cnt <= cur_cnt - 1'b1;
        end
    end

    // Interrupt flag: a new underflow beats a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (underflow) begin
            irq <= 1'b1;
        end else if (clr_wr) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/dn_timer.sv
module dn_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              slow_tick,
    input  logic              fast_tick,
    output logic              irq
);
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] cur_cnt;
    logic              ctl_en;
    logic              ctl_periodic;
    logic              ctl_fast;
    logic              load_wr;
    logic              clr_wr;
    tmr_state_e        state;

    tmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .cur_cnt      (cur_cnt),
        .load_q       (load_q),
        .ctl_en       (ctl_en),
        .ctl_periodic (ctl_periodic),
        .ctl_fast     (ctl_fast),
        .load_wr      (load_wr),
        .clr_wr       (clr_wr),
        .bus_rdata    (bus_rdata)
    );

    tmr_core #(.DATA_W(DATA_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .slow_tick    (slow_tick),
        .fast_tick    (fast_tick),
        .ctl_en       (ctl_en),
        .ctl_periodic (ctl_periodic),
        .ctl_fast     (ctl_fast),
        .load_wr      (load_wr),
        .clr_wr       (clr_wr),
        .bus_wdata    (bus_wdata),
        .load_q       (load_q),
        .cur_cnt      (cur_cnt),
        .state        (state),
        .irq          (irq)
    );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slow_tick,
    input logic              fast_tick,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] load_q,
    input logic [DATA_W-1:0] cur_cnt,
    input logic              ctl_en,
    input logic              ctl_periodic,
    input logic              ctl_fast,
    input logic              load_wr,
    input logic              clr_wr,
    input tmr_state_e        state,
    input logic              irq
);
    logic chk_tick;
    logic live;

    assign chk_tick = (ctl_fast && fast_tick) || (!ctl_fast && slow_tick);
    assign live     = ctl_en && (state != ST_EXPIRED) && chk_tick && !load_wr;

    p_load_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (cur_cnt == $past(bus_wdata)));

    p_off_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !load_wr) |=> $stable(cur_cnt));

    p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && (cur_cnt != '0)) |=> (cur_cnt == $past(cur_cnt) - 1'b1));

    p_expired_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_EXPIRED) && !load_wr) |=> (cur_cnt == '0));

    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live && ctl_periodic && (cur_cnt == '0)) |=> ((cur_cnt == $past(load_q)) && irq));

    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

    p_set_beats_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (live && (cur_cnt == '0) && clr_wr) |=> irq);
endmodule

bind dn_timer tmr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slow_tick    (slow_tick),
    .fast_tick    (fast_tick),
    .bus_wdata    (bus_wdata),
    .load_q       (load_q),
    .cur_cnt      (cur_cnt),
    .ctl_en       (ctl_en),
    .ctl_periodic (ctl_periodic),
    .ctl_fast     (ctl_fast),
    .load_wr      (load_wr),
    .clr_wr       (clr_wr),
    .state        (state),
    .irq          (irq)
);

// File: tb/tb_dn_timer.sv
module tb_dn_timer;
    localparam int DW = 32;
    localparam logic [3:0] A_LOAD = 4'h0;
    localparam logic [3:0] A_VAL  = 4'h4;
    localparam logic [3:0] A_CTL  = 4'h8;
    localparam logic [3:0] A_CLR  = 4'hC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = 4'h0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          slow_tick = 1'b0;
    logic          fast_tick = 1'b0;
    logic          irq;

    int n_chk = 0;
    int n_err = 0;

    dn_timer #(.DATA_W(DW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .slow_tick (slow_tick),
        .fast_tick (fast_tick),
        .irq       (irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus between two falling edges, then release
    task automatic cyc(input logic wr, input logic [3:0] a, input logic [DW-1:0] d,
                       input logic s, input logic f);
        @(negedge clk);
        bus_sel   = wr;
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = d;
        slow_tick = s;
        fast_tick = f;
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
        slow_tick = 1'b0;
        fast_tick = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic tick(input logic fast);
        cyc(1'b0, 4'h0, '0, !fast, fast);
    endtask

    task automatic rd(input logic [3:0] a, output logic [DW-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] model;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_LOAD, v); check("R1 load", v, 0);
        rd(A_VAL, v);  check("R1 value", v, 0);
        rd(A_CTL, v);  check("R1 ctrl", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R3 control layout
        wr(A_CTL, 32'h13); rd(A_CTL, v); check("R3 ctrl 0x13", v, 32'h13);
        wr(A_CTL, 32'hFFFF_FFFF); rd(A_CTL, v); check("R3 ctrl mask", v, 32'h13);
        wr(A_CTL, 32'hFFFF_FFEC); rd(A_CTL, v); check("R3 ctrl unused", v, 32'h0);

        // R2 and R5: load while disabled, ticks ignored
        wr(A_LOAD, 5); rd(A_VAL, v); check("R2 load sets value", v, 5);
        rd(A_LOAD, v); check("R2 load readback", v, 5);
        tick(1'b0); tick(1'b1); rd(A_VAL, v); check("R5 disabled hold", v, 5);

        // R4 and R6: tick select
        wr(A_CTL, 32'h01);
        tick(1'b1); rd(A_VAL, v); check("R4 fast ignored on slow", v, 5);
        tick(1'b0); rd(A_VAL, v); check("R6 slow decrement", v, 4);
        wr(A_CTL, 32'h11);
        tick(1'b0); rd(A_VAL, v); check("R4 slow ignored on fast", v, 4);
        tick(1'b1); rd(A_VAL, v); check("R6 fast decrement", v, 3);

        // R10 value register is read-only, clear reads zero
        wr(A_VAL, 99); rd(A_VAL, v); check("R10 value write ignored", v, 3);
        rd(A_CLR, v); check("R10 clear reads zero", v, 0);

        // R2 load while running
        wr(A_LOAD, 7); rd(A_VAL, v); check("R2 load while running", v, 7);

        // R7 one-shot sweep over both tick sources
        for (int src = 0; src < 2; src++) begin
            for (int n = 0; n < 7; n++) begin
                wr(A_CTL, 0);
                wr(A_CLR, 0);
                wr(A_LOAD, n);
                wr(A_CTL, 32'h01 | (src << 4));
                for (int k = 1; k <= n; k++) begin
                    tick(src[0]); rd(A_VAL, v); check("R6 sweep step", v, n - k);
                end
                check("R7 no irq before underflow", {31'b0, irq}, 0);
                tick(src[0]); rd(A_VAL, v);
                check("R7 underflow irq", {31'b0, irq}, 1);
                check("R7 holds zero", v, 0);
                tick(src[0]); tick(src[0]); rd(A_VAL, v);
                check("R7 stays zero", v, 0);
                check("R9 irq sticky", {31'b0, irq}, 1);
                wr(A_CLR, 32'hA5A5_0000 + n);
                check("R9 clear any data", {31'b0, irq}, 0);
            end
        end

        // R12 restart after expiry, then disable keeps count
        wr(A_LOAD, 2); rd(A_VAL, v); check("R12 restart value", v, 2);
        tick(1'b1); rd(A_VAL, v); check("R12 restart counts", v, 1);
        wr(A_CTL, 32'h10); tick(1'b1); rd(A_VAL, v); check("R12 disable holds", v, 1);

        // R8 periodic sweep
        for (int n = 0; n < 5; n++) begin
            wr(A_CTL, 0);
            wr(A_CLR, 0);
            wr(A_LOAD, n);
            wr(A_CTL, 32'h03);
            model = n;
            for (int k = 0; k < 3 * (n + 1); k++) begin
                tick(1'b0);
                rd(A_VAL, v);
                if (model == 0) begin
                    model = n;
                    check("R8 reload value", v, model);
                    check("R8 reload irq", {31'b0, irq}, 1);
                    wr(A_CLR, 1);
                    check("R9 clear after reload", {31'b0, irq}, 0);
                end else begin
                    model = model - 1;
                    check("R8 periodic step", v, model);
                    check("R8 no early irq", {31'b0, irq}, 0);
                end
            end
        end

        // R11 same-cycle priorities
        wr(A_CTL, 0); wr(A_CLR, 0); wr(A_LOAD, 0); wr(A_CTL, 32'h03);
        cyc(1'b1, A_CLR, 0, 1'b1, 1'b0);
        check("R11 underflow beats clear", {31'b0, irq}, 1);
        wr(A_CLR, 0);
        wr(A_LOAD, 3);
        cyc(1'b1, A_LOAD, 9, 1'b1, 1'b0);
        rd(A_VAL, v); check("R11 load beats tick", v, 9);
        wr(A_LOAD, 0);
        cyc(1'b1, A_LOAD, 0, 1'b1, 1'b0);
        check("R11 load blocks underflow", {31'b0, irq}, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule